// File: doc/BRIEF.md
# Load-Store Address and Extension Unit

This block sits between the decode stage and a synchronous SRAM in a 16-bit load-store processor. Memory is byte-addressed and little-endian. Each accepted request carries an addressing mode, a base value, an index value, a short unsigned immediate, an absolute address word, a size flag (byte or word), a sign flag for byte loads and, for stores, the source register value. The unit forms the effective address and drives the SRAM port in the same cycle. For stores it sends the data to the correct byte lanes. For loads it returns the 16-bit value to the register file. Byte loads are zero-extended or sign-extended as part of the access, and byte stores are truncated to the low byte, so software needs no separate extension instruction. The unit never performs arithmetic on the data and never writes back a base register.

Requests use valid/ready handshaking. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Load results leave on a valid/ready stream. `rsp_valid` rises in the cycle after the load is taken, and `rsp_data` stays fixed until `rsp_ready` is high at a clock edge. `req_ready` goes low while a load result is waiting and not being taken, so at most one result is ever outstanding. When `rsp_ready` stays high, one access completes every cycle. Stores and rejected accesses produce no response.

Top module: `ldst_access_unit`

## Requirements
- R1: Mode code 2'b00 forms the address as base plus the zero-extended 5-bit immediate, modulo 2^16; the index and absolute inputs have no effect in this mode.
- R2: Mode code 2'b01 forms the address as base plus index, modulo 2^16, with wrap-around past 16'hFFFF.
- R3: Mode codes 2'b10 and 2'b11 use the absolute address word unchanged.
- R4: A byte store asserts only one byte enable: `mem_be` = 2'b01 (low lane, bits 7:0) at an even address and 2'b10 (high lane, bits 15:8) at an odd address. The enabled lane carries `req_wdata[7:0]`, and the high byte of the source is ignored.
- R5: A word access asserts `mem_be` = 2'b11 and is little-endian: bits 7:0 belong to the even address and bits 15:8 to the following odd address.
- R6: A byte load with `req_signed` = 0 returns the selected memory byte in bits 7:0 and zeros in bits 15:8.
- R7: A byte load with `req_signed` = 1 returns the selected byte in bits 7:0 and copies of its bit 7 in bits 15:8.
- R8: A word load returns the 16-bit memory word unchanged.
- R9: A word request to an odd address pulses `align_err` in its acceptance cycle, drives neither `mem_en` nor `mem_we`, leaves memory unchanged and produces no response.
- R10: The SRAM port is driven in the acceptance cycle; a load's `rsp_valid` is high in the following cycle; stores give no response; after reset `req_ready` = 1 and `rsp_valid` = 0.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` is held and `req_ready` is low until the result is taken.
- R12: With `rsp_ready` held high, back-to-back requests are accepted one per cycle without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 2 | Addressing mode: 00 base+imm, 01 base+index, 10/11 absolute |
| req_base | input | 16 | Base register value |
| req_index | input | 16 | Index register value |
| req_imm | input | 5 | Unsigned immediate offset |
| req_abs | input | 16 | Absolute address word |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_signed | input | 1 | Byte load: 1 = sign-extend, 0 = zero-extend |
| req_wdata | input | 16 | Store source register value |
| align_err | output | 1 | Misaligned word request taken this cycle |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write strobe |
| mem_be | output | 2 | SRAM byte-lane enables |
| mem_addr | output | 16 | SRAM byte address (bit 0 selects the lane) |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data, valid the cycle after a read |
| rsp_valid | output | 1 | Load result present |
| rsp_ready | input | 1 | Register file takes the result |
| rsp_data | output | 16 | Load result |

## Verification
Each addressing mode is tried with unused fields set to junk values, and with operands that cross 16'hFFFF, to separate correct modular address sums from truncated sums or leaked fields. Byte stores to even and odd addresses, with a source whose high byte is nonzero, are read back as words, which shows whether the lane steering and the truncation are right. Byte loads of bytes with bit 7 set and clear, in both extension modes, tell zero-fill apart from sign-fill and show which lane was selected. A misaligned word store followed by a word read-back, a stalled result stream, and an uninterrupted burst separate the error suppression, the hold behaviour and full throughput.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    MODE_BASE_IMM = 2'b00,
    MODE_BASE_IDX = 2'b01,
    MODE_ABS      = 2'b10
  } addr_mode_e;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] abs_addr,
  output logic [ADDR_W-1:0] addr
);
  import ldst_pkg::*;

  logic [ADDR_W-1:0] imm_ext;
  assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm};

  // Sums drop the carry out: wrap-around is modulo 2^ADDR_W.
  always_comb begin
    case (addr_mode_e'(mode))
      MODE_BASE_IMM: addr = base + imm_ext;
      MODE_BASE_IDX: addr = base + index;
      default:       addr = abs_addr;
    endcase
  end
endmodule

// File: rtl/ldst_wr_steer.sv
module ldst_wr_steer #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              word,
  input  logic [LSEL_W-1:0] lane_sel,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = word | (lane_sel == LSEL_W'(i));
    // A byte store replicates the low byte on every lane; only the enabled lane lands.
    assign dout[i*LANE_W +: LANE_W] = word ? din[i*LANE_W +: LANE_W] : din[LANE_W-1:0];
  end
endmodule

// File: rtl/ldst_rd_extend.sv
module ldst_rd_extend #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              word,
  input  logic              sign,
  input  logic [LSEL_W-1:0] lane_sel,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [LANE_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_sel == LSEL_W'(i)) picked = rdata[i*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    if (word) result = rdata;
    else      result = {{(DATA_W-LANE_W){sign & picked[LANE_W-1]}}, picked};
  end
endmodule

// File: rtl/ldst_access_unit.sv
module ldst_access_unit #(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 5,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [ADDR_W-1:0] req_abs,
  input  logic              req_store,
  input  logic              req_word,
  input  logic              req_signed,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              align_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic [ADDR_W-1:0] eff_addr;
  logic [LSEL_W-1:0] lane_now;
  logic              accept;
  logic              misaligned;

  // Load in flight: SRAM data is on mem_rdata this cycle.
  logic              pend_valid;
  logic              pend_word;
  logic              pend_sign;
  logic [LSEL_W-1:0] pend_lane;
  // Result parked because the consumer stalled.
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] fmt_data;

  ldst_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .mode(req_mode), .base(req_base), .index(req_index),
    .imm(req_imm), .abs_addr(req_abs), .addr(eff_addr)
  );

  assign lane_now   = eff_addr[LSEL_W-1:0];
  assign misaligned = req_word & (|lane_now);
  assign req_ready  = !hold_valid && !(pend_valid && !rsp_ready);
  assign accept     = req_valid && req_ready;

  ldst_wr_steer #(.LANE_W(LANE_W), .LANES(LANES)) u_steer (
    .word(req_word), .lane_sel(lane_now), .din(req_wdata),
    .be(mem_be), .dout(mem_wdata)
  );

  assign mem_addr  = eff_addr;
  assign mem_en    = accept && !misaligned;
  assign mem_we    = accept && !misaligned && req_store;
  assign align_err = accept && misaligned;

  ldst_rd_extend #(.LANE_W(LANE_W), .LANES(LANES)) u_ext (
    .word(pend_word), .sign(pend_sign), .lane_sel(pend_lane),
    .rdata(mem_rdata), .result(fmt_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= 1'b0;
      pend_sign  <= 1'b0;
      pend_lane  <= '0;
    end else begin
      pend_valid <= mem_en && !req_store;
      if (mem_en && !req_store) begin
        pend_word <= req_word;
        pend_sign <= req_signed;
        pend_lane <= lane_now;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (pend_valid && !rsp_ready) begin
      hold_valid <= 1'b1;
      hold_data  <= fmt_data;
    end else if (hold_valid && rsp_ready) begin
      hold_valid <= 1'b0;
    end
  end

  assign rsp_valid = pend_valid | hold_valid;
  assign rsp_data  = hold_valid ? hold_data : fmt_data;
endmodule

// File: rtl/ldst_access_unit_chk.sv
module ldst_access_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic              req_word,
  input logic              align_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_be,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data
);
  // R4: a byte access enables exactly the lane picked by the low address bit
  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_word) |-> ($countones(mem_be) == 1 && mem_be[1] == mem_addr[0]));

  // R5: a word access enables all lanes at an even address
  assert_word_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && req_word) |-> (mem_be == 2'b11 && !mem_addr[0]));

  // R9: a misaligned request touches no memory
  assert_misalign_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_en && !mem_we));

  // R10: a load taken now has a result next cycle
  assert_load_result_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_store) |=> rsp_valid);

  // R10: the memory port is only driven for a taken request
  assert_port_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (req_valid && req_ready));

  // R11: a stalled result is held steady
  assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11: no new request while a result is refused
  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind ldst_access_unit ldst_access_unit_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_store(req_store), .req_word(req_word), .align_err(align_err),
  .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/ldst_access_unit_tb.sv
`timescale 1ns/1ps
module ldst_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_mode = 2'b00;
  logic [15:0] req_base = '0, req_index = '0, req_abs = '0, req_wdata = '0;
  logic [4:0]  req_imm = '0;
  logic        req_store = 1'b0, req_word = 1'b0, req_signed = 1'b0;
  logic        align_err, mem_en, mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int last_waits = 0;
  bit done = 1'b0;

  logic [7:0]  mem_b   [0:511];
  logic [7:0]  ref_mem [0:511];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ldst_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
    .req_imm(req_imm), .req_abs(req_abs), .req_store(req_store),
    .req_word(req_word), .req_signed(req_signed), .req_wdata(req_wdata),
    .align_err(align_err), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // Synchronous SRAM model: read data appears the cycle after the read.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[0]) mem_b[{mem_addr[8:1], 1'b0}] <= mem_wdata[7:0];
        if (mem_be[1]) mem_b[{mem_addr[8:1], 1'b1}] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem_b[{mem_addr[8:1], 1'b1}], mem_b[{mem_addr[8:1], 1'b0}]};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_load(input logic [15:0] a, input logic wd,
                                             input logic sx);
    logic [7:0] b;
    if (wd) return {ref_mem[{a[8:1], 1'b1}], ref_mem[{a[8:1], 1'b0}]};
    b = ref_mem[a[8:0]];
    return {{8{sx & b[7]}}, b};
  endfunction

  // Driver: called just after a falling edge, returns after the request is taken.
  task automatic issue(input logic [1:0] mode, input logic [15:0] base,
                       input logic [15:0] idx, input logic [4:0] imm,
                       input logic [15:0] absa, input logic st, input logic wd,
                       input logic sx, input logic [15:0] data,
                       input logic [15:0] exp_addr, input string tag);
    logic [1:0] exp_be;
    int waits = 0;
    req_mode = mode; req_base = base; req_index = idx; req_imm = imm;
    req_abs = absa; req_store = st; req_word = wd; req_signed = sx;
    req_wdata = data; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    last_waits = waits;
    if (wd && exp_addr[0]) begin
      chk(align_err == 1'b1, tag, "align_err", {15'd0, align_err}, 16'd1);
      chk(mem_en == 1'b0 && mem_we == 1'b0, tag, "mem_en on misaligned",
          {14'd0, mem_en, mem_we}, 16'd0);
    end else begin
      exp_be = wd ? 2'b11 : (exp_addr[0] ? 2'b10 : 2'b01);
      chk(mem_addr == exp_addr, tag, "mem_addr", mem_addr, exp_addr);
      chk(mem_be == exp_be, tag, "mem_be", {14'd0, mem_be}, {14'd0, exp_be});
      chk(mem_we == st, tag, "mem_we", {15'd0, mem_we}, {15'd0, st});
      if (st) begin
        if (wd) begin
          chk(mem_wdata == data, tag, "word wdata", mem_wdata, data);
          ref_mem[{exp_addr[8:1], 1'b0}] = data[7:0];
          ref_mem[{exp_addr[8:1], 1'b1}] = data[15:8];
        end else begin
          chk((exp_addr[0] ? mem_wdata[15:8] : mem_wdata[7:0]) == data[7:0], tag,
              "byte lane data",
              {8'd0, exp_addr[0] ? mem_wdata[15:8] : mem_wdata[7:0]}, {8'd0, data[7:0]});
          ref_mem[exp_addr[8:0]] = data[7:0];
        end
      end else begin
        exp_q.push_back(model_load(exp_addr, wd, sx));
        tag_q.push_back(tag);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
  endtask

  // Monitor: compares each accepted result against the scoreboard.
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", rsp_data, 16'h0000);
        end else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(rsp_data == e, t, "rsp_data", rsp_data, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem_b[i]   = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R10", "reset req_ready", {15'd0, req_ready}, 16'd1);
    chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk(mem_en == 1'b0, "R10", "reset mem_en", {15'd0, mem_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5: absolute word store, little-endian lanes
    issue(2'b10, 16'h7777, 16'h3333, 5'd9, 16'h0040, 1, 1, 0, 16'hBEEF, 16'h0040, "R3");
    idle(); #1;
    chk(rsp_valid == 1'b0, "R10", "store gives no response", {15'd0, rsp_valid}, 16'd0);
    @(negedge clk);

    // R1 R8: base+imm word load, index ignored
    issue(2'b00, 16'h0038, 16'h1234, 5'd8, 16'h0100, 0, 1, 0, 16'h0, 16'h0040, "R1");
    // R5: byte halves of the stored word sit little-endian
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0040, 0, 0, 0, 16'h0, 16'h0040, "R5");
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0041, 0, 0, 0, 16'h0, 16'h0041, "R5");

    // R2 R4: base+index byte store to odd address, high source byte ignored
    issue(2'b01, 16'h0050, 16'h0003, 5'd1, 16'h0000, 1, 0, 0, 16'hAB80, 16'h0053, "R4");
    // R6 R7: zero and sign extension of 0x80
    issue(2'b01, 16'h0050, 16'h0003, 5'd0, 16'h0000, 0, 0, 0, 16'h0, 16'h0053, "R6");
    issue(2'b01, 16'h0050, 16'h0003, 5'd0, 16'h0000, 0, 0, 1, 16'h0, 16'h0053, "R7");
    // R4: the neighbouring even byte is untouched
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0052, 0, 1, 0, 16'h0, 16'h0052, "R4");

    // R4 R7: even-lane byte store of 0x7F, sign load stays positive
    issue(2'b00, 16'h0060, 16'hFFFF, 5'd0, 16'h0000, 1, 0, 0, 16'h127F, 16'h0060, "R4");
    issue(2'b00, 16'h0060, 16'h0000, 5'd0, 16'h0000, 0, 0, 1, 16'h0, 16'h0060, "R7");
    issue(2'b00, 16'h0060, 16'h0000, 5'd0, 16'h0000, 0, 1, 0, 16'h0, 16'h0060, "R8");

    // R2 R1: wrap-around
    issue(2'b01, 16'hFFF0, 16'h0014, 5'd0, 16'h0000, 0, 1, 0, 16'h0, 16'h0004, "R2");
    issue(2'b00, 16'hFFFE, 16'h0000, 5'd4, 16'h0000, 0, 1, 0, 16'h0, 16'h0002, "R1");
    // R3: code 11 acts as absolute
    issue(2'b11, 16'h0100, 16'h0100, 5'd3, 16'h0024, 0, 1, 0, 16'h0, 16'h0024, "R3");

    // R9: misaligned word store and load
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0041, 1, 1, 0, 16'h5555, 16'h0041, "R9");
    issue(2'b00, 16'h0040, 16'h0, 5'd1, 16'h0, 0, 1, 0, 16'h0, 16'h0041, "R9");
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0040, 0, 1, 0, 16'h0, 16'h0040, "R9");

    // R12: burst without stalls
    for (int k = 0; k < 4; k++) begin
      issue(2'b10, 16'h0, 16'h0, 5'd0, 16'(16'h0080 + 2 * k), 0, k[0], k[1],
            16'h0, 16'(16'h0080 + 2 * k), "R12");
      chk(last_waits == 0, "R12", "burst stall cycles", 16'(last_waits), 16'd0);
    end
    idle();
    @(negedge clk);

    // R11: back-pressure
    rsp_ready = 1'b0;
    issue(2'b10, 16'h0, 16'h0, 5'd0, 16'h0053, 0, 0, 1, 16'h0, 16'h0053, "R11");
    idle(); #1;
    chk(rsp_valid == 1'b1, "R11", "rsp_valid during stall", {15'd0, rsp_valid}, 16'd1);
    chk(req_ready == 1'b0, "R11", "req_ready during stall", {15'd0, req_ready}, 16'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid == 1'b1 && rsp_data == 16'hFF80, "R11", "held data", rsp_data, 16'hFF80);
      chk(req_ready == 1'b0, "R11", "req_ready held low", {15'd0, req_ready}, 16'd0);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R11", "released rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk(req_ready == 1'b1, "R11", "released req_ready", {15'd0, req_ready}, 16'd1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "pending results", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule